// File: doc/BRIEF.md
# Auto-Idle Parallel Memory Read Port

This block is a clock-sampled model of the read side of an asynchronous parallel memory. Its controls are an active-low chip select and an active-low output enable. On every rising edge of the system clock it samples the select, the output enable and the address. When both controls are sampled low, it drives a 16-bit tri-state data bus. It fetches the addressed word from a small register file, and the word reaches the bus after a fixed, parameterised number of clock edges.

The block also reports a power state. With the chip deselected, the state is standby. While a read is in progress, the state is active. Once a read has completed and nothing has moved, the block drops into an automatic low-power idle state and keeps the word on the bus. Any sampled change on the address or the controls wakes it at once, and the next word arrives with the same latency as from the active state. After reset with the chip held selected, idle entry stays blocked until the address changes or the chip is deselected once.

Top module: `pmem_read_port`

## Requirements
- R1: `dq_oe` is high, and `dq` is driven, exactly in the cycle after an edge that sampled both `ce_n` and `oe_n` low. Otherwise `dq_oe` is low and `dq` is all high-impedance.
- R2: `pwr_state` uses these codes: 2'b00 standby, 2'b01 active, 2'b10 idle. The code 2'b11 never appears. After an edge that sampled `ce_n` high, the state is standby.
- R3: A new word appears on `dq` at the LAT-th rising edge, counting the edge that first samples the new address or the control assertion as the first. An address or control change sampled before that edge restarts the count, and the word of the abandoned access never appears.
- R4: With idle entry allowed, the state becomes idle at the edge after the one that put the word on the bus. While idle, the bus stays enabled and keeps the same word.
- R5: When a change in the address, `ce_n` or `oe_n` is sampled in the idle state, the state is active after that edge. The new word keeps the LAT latency of R3.
- R6: After reset, with `ce_n` held low and no address change, the state stays active after a completed read. A sampled address change, or one sampled `ce_n` high, allows idle entry from then on.
- R7: The word at address a is the low 16 bits of (a * 0x3B1D) XOR 0xA5C3.
- R8: While `rst_n` is low, `dq_oe` is low and the state is standby. Pin levels held through the release of reset are not counted as transitions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (4) | Word address |
| dq | inout | DATA_W (16) | Tri-state read data bus |
| dq_oe | output | 1 | High while the block drives `dq` |
| pwr_state | output | 2 | Power state: 00 standby, 01 active, 10 idle |

## Verification
A wrong transition flag or a wrong access count shows on `dq` within LAT edges of the stimulus, as a word that arrives early, arrives late, or belongs to an abandoned address. A bad idle-permission bit shows one edge after a completed read: `pwr_state` reads active where idle is due, or idle where it must be blocked after reset. A power register that misses a wake-up stays idle one edge after an address or control change, and the checker flags this on the next edge.

// File: rtl/pmem_rd_pkg.sv
// Shared types and helpers for the auto-idle read port.
// Assumes: power codes are fixed at 2 bits, as seen at the top-level port.
package pmem_rd_pkg;

    typedef enum logic [1:0] {
        PWR_STANDBY = 2'b00,
        PWR_ACTIVE  = 2'b01,
        PWR_IDLE    = 2'b10
    } pwr_e;

    // Content of a cell, computed from its index (no stored table).
    function automatic logic [31:0] cell_pattern(input int unsigned idx,
                                                 input logic [31:0] seed);
        logic [31:0] prod;
        prod = idx * 32'h0000_3B1D;
        return prod ^ seed;
    endfunction

endpackage

// File: rtl/pmem_pin_sampler.sv
// Keeps the previous sample of the asynchronous pins and flags changes.
// Assumes: pins are already synchronous to clk. The reset loads the live
// pin levels so that levels held through reset are not transitions.
module pmem_pin_sampler #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_chg,
    output logic              ctl_chg,
    output logic              idle_armed
);

    logic              smp_ce_n;
    logic              smp_oe_n;
    logic [ADDR_W-1:0] smp_addr;
    logic              armed_q;

    // Changes between the live pins and the previous sample.
    assign addr_chg   = (addr != smp_addr);
    assign ctl_chg    = (ce_n != smp_ce_n) || (oe_n != smp_oe_n);
    assign idle_armed = armed_q;

    // Take the sample every edge. Idle permission is set for good by an address change or by deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_ce_n <= ce_n;
            smp_oe_n <= oe_n;
            smp_addr <= addr;
            armed_q  <= 1'b0;
        end else begin
            smp_ce_n <= ce_n;
            smp_oe_n <= oe_n;
            smp_addr <= addr;
            armed_q  <= armed_q | addr_chg | ce_n;
        end
    end

endmodule

// File: rtl/pmem_access_timer.sv
// Counts the access latency of a read and says when the word is fetched.
// Assumes: LAT >= 1. A restart counts the current edge as access cycle 1.
module pmem_access_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic restart,
    output logic fetch,
    output logic done
);

    localparam int CNT_W = $clog2(LAT + 1) + 1;
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    // Next count: cleared when no read, restarted on change, saturating at LAT.
    always_comb begin
        if (!rd_req) begin
            cnt_nxt = '0;
        end else if (restart) begin
            cnt_nxt = ONE_C;
        end else if (cnt_q == LAT_C) begin
            cnt_nxt = LAT_C;
        end else begin
            cnt_nxt = cnt_q + ONE_C;
        end
    end

    assign fetch = rd_req && (cnt_nxt == LAT_C) && (restart || (cnt_q != LAT_C));
    assign done  = (cnt_q == LAT_C);

    // Hold the access count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/pmem_cell_array.sv
// Small read-only register file with a computed reset image, plus the
// output word register that feeds the data bus.
// Assumes: DATA_W <= 32. The cells are never written after reset.
module pmem_cell_array #(
    parameter int          ADDR_W = 4,
    parameter int          DATA_W = 16,
    parameter logic [31:0] SEED   = 32'h0000_A5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] word
);

    import pmem_rd_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] word_q;

    // Load every cell with its pattern at reset, then hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= DATA_W'(cell_pattern(i, SEED));
            end
        end
    end

    // Capture the addressed word when the access completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (fetch) begin
            word_q <= cells[rd_addr];
        end
    end

    assign word = word_q;

endmodule

// File: rtl/pmem_power_fsm.sv
// Tracks the power state: standby when deselected, idle after a finished
// read when permitted, active otherwise.
// Assumes: done means the word is already on the bus.
module pmem_power_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   done,
    input  logic                   any_chg,
    input  logic                   idle_armed,
    output pmem_rd_pkg::pwr_e      state
);

    import pmem_rd_pkg::*;

    pwr_e state_q;

    // Choose the power state from the current sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_STANDBY;
        end else if (ce_n) begin
            state_q <= PWR_STANDBY;
        end else if (done && !any_chg && idle_armed) begin
            state_q <= PWR_IDLE;
        end else begin
            state_q <= PWR_ACTIVE;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/pmem_read_port.sv
// Top of the auto-idle read port: samples the pins, times the access,
// fetches the word, drives the tri-state bus and reports the power state.
// Assumes: pins are synchronous to clk. The bus enable lags the pins by one edge.
module pmem_read_port #(
    parameter int          ADDR_W = 4,
    parameter int          DATA_W = 16,
    parameter int          LAT    = 3,
    parameter logic [31:0] SEED   = 32'h0000_A5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] dq,
    output logic              dq_oe,
    output logic [1:0]        pwr_state
);

    import pmem_rd_pkg::*;

    logic              addr_chg;
    logic              ctl_chg;
    logic              any_chg;
    logic              idle_armed;
    logic              rd_req;
    logic              fetch;
    logic              done;
    logic              oe_q;
    logic [DATA_W-1:0] word;
    pwr_e              state;

    assign rd_req  = !ce_n && !oe_n;
    assign any_chg = addr_chg || ctl_chg;

    pmem_pin_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .addr_chg   (addr_chg),
        .ctl_chg    (ctl_chg),
        .idle_armed (idle_armed)
    );

    pmem_access_timer #(.LAT(LAT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .restart (any_chg),
        .fetch   (fetch),
        .done    (done)
    );

    pmem_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEED   (SEED)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .fetch   (fetch),
        .rd_addr (addr),
        .word    (word)
    );

    pmem_power_fsm u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .done       (done),
        .any_chg    (any_chg),
        .idle_armed (idle_armed),
        .state      (state)
    );

    // Register the bus enable from the sampled controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= rd_req;
        end
    end

    assign dq        = oe_q ? word : {DATA_W{1'bz}};
    assign dq_oe     = oe_q;
    assign pwr_state = state;

endmodule

// File: rtl/pmem_read_port_chk.sv
// Checker for the auto-idle read port, bound to every instance of the top.
// Assumes: the power codes given in the brief.
module pmem_read_port_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic [1:0]        pwr_state
);

    // R1
    bus_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dq_oe == $past(!ce_n && !oe_n)));

    // R2
    standby_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce_n)) |-> (pwr_state == 2'b00));

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'b11);

    // R4
    idle_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b10) |-> dq_oe);

    // R5
    wake_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state == 2'b10) &&
         ((addr != $past(addr)) || (ce_n != $past(ce_n)) || (oe_n != $past(oe_n))))
        |=> (pwr_state != 2'b10));

endmodule

bind pmem_read_port pmem_read_port_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .dq_oe     (dq_oe),
    .pwr_state (pwr_state)
);

// File: tb/test_pmem_read_port.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected port values per cycle and
// a monitor on the falling edge pops and compares them.
module test_pmem_read_port;

    localparam int LAT = 3;
    localparam logic [1:0] ST_SB = 2'b00;
    localparam logic [1:0] ST_AC = 2'b01;
    localparam logic [1:0] ST_ID = 2'b10;

    typedef struct {
        int          at;
        int          kind;   // 0 dq_oe, 1 dq word, 2 power, 3 high-Z
        logic [15:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b0;
    logic        oe_n = 1'b0;
    logic [3:0]  addr = 4'd5;
    wire  [15:0] dq;
    logic        dq_oe;
    logic [1:0]  pwr_state;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sbq[$];

    pmem_read_port #(.ADDR_W(4), .DATA_W(16), .LAT(LAT)) i_pmem_read_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .dq        (dq),
        .dq_oe     (dq_oe),
        .pwr_state (pwr_state)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected cell content (R7).
    function automatic logic [15:0] wexp(input int a);
        logic [31:0] p;
        p = a * 32'h0000_3B1D;
        return p[15:0] ^ 16'hA5C3;
    endfunction

    task automatic push(input int d, input int kind, input logic [15:0] v, input string req);
        exp_t e;
        e.at = cyc + d; e.kind = kind; e.val = v; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic set_pins(input logic c, input logic o, input logic [3:0] a);
        @(negedge clk);
        ce_n = c; oe_n = o; addr = a;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare every item due after the latest rising edge.
    always @(negedge clk) begin
        while (sbq.size() != 0 && sbq[0].at <= cyc) begin
            exp_t e;
            logic [15:0] act;
            e = sbq.pop_front();
            checks++;
            case (e.kind)
                0: act = {15'd0, dq_oe};
                1: act = dq;
                2: act = {14'd0, pwr_state};
                default: act = dq;
            endcase
            if (e.kind == 3) begin
                if (dq !== 16'hzzzz) begin
                    errors++;
                    $display("FAIL %s cyc %0d: dq actual %h expected zzzz", e.req, cyc, dq);
                end
            end else if (act !== e.val || e.at != cyc) begin
                errors++;
                $display("FAIL %s cyc %0d kind %0d: actual %h expected %h", e.req, cyc, e.kind, act, e.val);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state with the chip held selected
        repeat (2) @(negedge clk);
        push(1, 0, 16'd0, "R8"); push(1, 2, ST_SB, "R8"); push(1, 3, 0, "R1");
        drain();
        rst_n = 1'b1;
        // R3/R7 read completes from held pins; R6 idle stays blocked
        push(LAT, 1, wexp(5), "R3");
        push(LAT + 4, 0, 16'd1, "R1"); push(LAT + 4, 2, ST_AC, "R6");
        drain();

        // Address change: latency and idle entry (R3, R4)
        set_pins(0, 0, 4'd9);
        push(1, 0, 16'd1, "R1"); push(1, 2, ST_AC, "R2");
        push(LAT - 1, 1, wexp(5), "R3");
        push(LAT, 1, wexp(9), "R3"); push(LAT, 2, ST_AC, "R4");
        push(LAT + 1, 2, ST_ID, "R4");
        push(LAT + 3, 1, wexp(9), "R4"); push(LAT + 3, 0, 16'd1, "R4");
        drain();

        // Wake from idle by address change (R5)
        set_pins(0, 0, 4'd2);
        push(1, 2, ST_AC, "R5");
        push(LAT - 1, 1, wexp(9), "R5");
        push(LAT, 1, wexp(2), "R5");
        push(LAT + 1, 2, ST_ID, "R4");
        drain();

        // Output enable released with a new address (R1, R2)
        set_pins(0, 1, 4'd7);
        push(1, 0, 16'd0, "R1"); push(1, 3, 0, "R1"); push(1, 2, ST_AC, "R2");
        push(3, 2, ST_AC, "R2");
        drain();
        set_pins(0, 0, 4'd7);
        push(1, 0, 16'd1, "R5"); push(1, 2, ST_AC, "R5");
        push(LAT, 1, wexp(7), "R5"); push(LAT + 1, 2, ST_ID, "R4");
        drain();

        // Deselect then reselect (R2, R5)
        set_pins(1, 0, 4'd7);
        push(1, 0, 16'd0, "R1"); push(1, 3, 0, "R1"); push(1, 2, ST_SB, "R2");
        push(4, 2, ST_SB, "R2");
        drain();
        set_pins(0, 0, 4'd7);
        push(1, 2, ST_AC, "R5"); push(LAT, 1, wexp(7), "R3"); push(LAT + 1, 2, ST_ID, "R4");
        drain();

        // Address boundaries (R7)
        set_pins(0, 0, 4'd15);
        push(LAT, 1, wexp(15), "R7"); push(LAT + 1, 2, ST_ID, "R4");
        drain();
        set_pins(0, 0, 4'd0);
        push(LAT, 1, wexp(0), "R7");
        drain();

        // Restart of an access before completion (R3)
        set_pins(0, 0, 4'd3);
        drain();
        repeat (LAT + 2) @(negedge clk);
        set_pins(0, 0, 4'd8);
        set_pins(0, 0, 4'd11);
        push(LAT - 1, 1, wexp(3), "R3"); push(LAT, 1, wexp(11), "R3");
        drain();

        // Second reset, selected: idle blocked until a deselect (R6)
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = 4'd3;
        repeat (2) @(negedge clk);
        push(1, 2, ST_SB, "R8");
        drain();
        rst_n = 1'b1;
        push(LAT, 1, wexp(3), "R6"); push(LAT + 4, 2, ST_AC, "R6");
        drain();
        set_pins(1, 0, 4'd3);
        set_pins(0, 0, 4'd3);
        push(1, 2, ST_AC, "R6"); push(LAT, 1, wexp(3), "R6");
        push(LAT + 1, 2, ST_ID, "R6");
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule